// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Bridge

This block lets host software bit-bang a three-wire serial EEPROM through side-effect offsets in a device's configuration space. A write to one offset raises chip select and sets the serial clock and data-in lines from two bits of the write data. A write to a second offset lowers all three lines. Neither write reaches the rest of configuration space. The EEPROM's data-out line is returned through the low byte of a one-byte read of offset 0. When data-out is low that byte reads as zero. Otherwise the normal value is returned.

All other configuration traffic passes unchanged to a default configuration register port outside this block. The EEPROM model is included. It holds 64 sixteen-bit words and answers a read command. At reset it holds a fixed adapter image whose last word makes the 16-bit word sum come out to a fixed constant.

Top module: `cfg_eeprom_bridge`

## Requirements
- R1: A configuration write at offset 0x80 sets chip select high, serial clock to write-data bit 7 and data-in to write-data bit 6. The write is not forwarded to the default port.
- R2: A configuration write at offset 0xC0 drives chip select, serial clock and data-in low. The write is not forwarded.
- R3: A read of offset 0 with size 1 returns the default port's value with its low byte forced to 0x00 when EEPROM data-out is low. When data-out is high, the value is returned unchanged.
- R4: Every write at any other offset, and every read, is forwarded with its offset, size and data unchanged. A read returns the default port's data unchanged, except in the R3 case (size is a byte count of 1, 2 or 4).
- R5: The EEPROM samples data-in on a rising serial clock while chip select is high. Zeros before a 1 start bit are ignored. The start bit is followed by a 2-bit opcode and a 6-bit word address, all MSB first. Opcode 2'b10 is a read.
- R6: On the rising edge that carries the last address bit of a read, data-out goes to a dummy 0. Each following rising edge presents the next of the 16 data bits, MSB first, and 0 after the last one.
- R7: Data-out is high whenever a read's data is not being shifted out. This covers waiting for a start bit, receiving a command, and after a non-read opcode.
- R8: Chip select low abandons any partial command and returns the EEPROM to waiting for a start bit, with data-out high.
- R9: Words 0 to 15 of the default image hold 0x0057. Word 32 holds 0x0F07, word 33 holds 0x0400 and word 34 holds 0x0007. All other words except 63 hold 0.
- R10: Word 63 holds 0x1234 minus the 16-bit sum of words 0 to 62. With the R9 image this is 0xF9B6.
- R11: After reset, chip select, clock and data-in are low and data-out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_size | input | 3 | Access size in bytes (1, 2, 4) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational) |
| dflt_wr | output | 1 | Forwarded write strobe |
| dflt_rd | output | 1 | Forwarded read strobe |
| dflt_off | output | 8 | Forwarded offset |
| dflt_size | output | 3 | Forwarded size |
| dflt_wdata | output | 32 | Forwarded write data |
| dflt_rdata | input | 32 | Read data from the default handler |

## Verification
Reads are tried on words from each region of the image: the repeated pattern, the adapter settings, an all-zero word and the checksum word. This separates a wrong word, a bit-order error and a missing dummy bit. Leading zeros before the start bit, an abort halfway through a command, and a non-read opcode show whether the command decoder keeps or loses its place. One-byte, two-byte and four-byte reads at offset 0 and elsewhere, taken while data-out is low, show that the gating applies only to the single case R3 defines. Writes at the two control offsets and at an ordinary offset show which traffic reaches the default port.

// File: rtl/eebr_pkg.sv
package eebr_pkg;
    localparam int CFG_OFF_W = 8;
    localparam int CFG_DW    = 32;
    localparam int CFG_SZ_W  = 3;
    localparam logic [CFG_OFF_W-1:0] EE_CLK_OFF  = 8'h80;
    localparam logic [CFG_OFF_W-1:0] EE_SEL_OFF  = 8'hC0;
    localparam logic [CFG_OFF_W-1:0] EE_GATE_OFF = 8'h00;
    localparam int SK_BIT = 7;
    localparam int DI_BIT = 6;

    localparam int EE_WORDS = 64;
    localparam int EE_DW    = 16;
    localparam int EE_AW    = $clog2(EE_WORDS);
    localparam int EE_OP_W  = 2;
    localparam int EE_CMD_W = EE_OP_W + EE_AW;
    localparam logic [EE_OP_W-1:0] EE_OP_READ = 2'b10;
    localparam logic [EE_DW-1:0]   EE_SUM_TARGET = 16'h1234;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    typedef enum logic [1:0] {
        EE_WAIT  = 2'd0,
        EE_CMD   = 2'd1,
        EE_SHIFT = 2'd2,
        EE_HOLD  = 2'd3
    } ee_state_e;

    function automatic logic [7:0] img_byte(int i);
        if (i < 32) return (i % 2 == 0) ? 8'h57 : 8'h00;
        case (i)
            64:      return 8'h07;
            65:      return 8'h0F;
            67:      return 8'h04;
            68:      return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [EE_DW-1:0] img_plain(int w);
        return {img_byte(2 * w + 1), img_byte(2 * w)};
    endfunction

    function automatic logic [EE_DW-1:0] img_sum();
        logic [EE_DW-1:0] s;
        s = '0;
        for (int w = 0; w < EE_WORDS - 1; w++) s = s + img_plain(w);
        return s;
    endfunction

    localparam logic [EE_DW-1:0] EE_CHECK_WORD = EE_SUM_TARGET - img_sum();

    function automatic logic [EE_DW-1:0] img_word(logic [EE_AW-1:0] a);
        if (int'(a) == EE_WORDS - 1) return EE_CHECK_WORD;
        return img_plain(int'(a));
    endfunction
endpackage

// File: rtl/eebr_pins.sv
module eebr_pins
    import eebr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     drive,
    input  logic     release_all,
    input  logic     sk_in,
    input  logic     di_in,
    output ee_pins_t pins
);
    always_ff @(posedge clk) begin
        if (rst || release_all) begin
            pins <= '{cs: 1'b0, sk: 1'b0, di: 1'b0};
        end else if (drive) begin
            pins <= '{cs: 1'b1, sk: sk_in, di: di_in};
        end
    end
endmodule

// File: rtl/eebr_eeprom.sv
module eebr_eeprom
    import eebr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ee_pins_t pins,
    output logic     dout
);
    localparam int CNT_W = $clog2(EE_CMD_W);

    ee_state_e            st;
    logic                 sk_q;
    logic [CNT_W-1:0]     cnt;
    logic [EE_CMD_W-1:0]  cmd;
    logic [EE_CMD_W-1:0]  cmd_next;
    logic [EE_DW:0]       out_sr;
    logic                 rise;

    assign rise     = pins.cs && pins.sk && !sk_q;
    assign cmd_next = {cmd[EE_CMD_W-2:0], pins.di};
    assign dout     = (st == EE_SHIFT) ? out_sr[EE_DW] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EE_WAIT;
            sk_q   <= 1'b0;
            cnt    <= '0;
            cmd    <= '0;
            out_sr <= '0;
        end else begin
            sk_q <= pins.sk;
            if (!pins.cs) begin
                st  <= EE_WAIT;
                cnt <= '0;
            end else if (rise) begin
                case (st)
                    EE_WAIT: begin
                        if (pins.di) begin
                            st  <= EE_CMD;
                            cnt <= '0;
                        end
                    end
                    EE_CMD: begin
                        cmd <= cmd_next;
                        if (cnt == CNT_W'(EE_CMD_W - 1)) begin
                            if (cmd_next[EE_CMD_W-1 -: EE_OP_W] == EE_OP_READ) begin
                                out_sr <= {1'b0, img_word(cmd_next[EE_AW-1:0])};
                                st     <= EE_SHIFT;
                            end else begin
                                st <= EE_HOLD;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    EE_SHIFT: out_sr <= {out_sr[EE_DW-1:0], 1'b0};
                    default:  st <= EE_HOLD;
                endcase
            end
        end
    end
endmodule

// File: rtl/eebr_cfg_route.sv
module eebr_cfg_route
    import eebr_pkg::*;
(
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic [CFG_SZ_W-1:0]  cfg_size,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    input  logic                 ee_do,
    output logic                 pin_drive,
    output logic                 pin_release,
    output logic                 dflt_wr,
    output logic                 dflt_rd,
    output logic [CFG_OFF_W-1:0] dflt_off,
    output logic [CFG_SZ_W-1:0]  dflt_size,
    output logic [CFG_DW-1:0]    dflt_wdata,
    input  logic [CFG_DW-1:0]    dflt_rdata
);
    logic gate_hit;

    assign pin_drive   = cfg_wr && (cfg_off == EE_CLK_OFF);
    assign pin_release = cfg_wr && (cfg_off == EE_SEL_OFF);
    assign dflt_wr     = cfg_wr && !pin_drive && !pin_release;
    assign dflt_rd     = cfg_rd;
    assign dflt_off    = cfg_off;
    assign dflt_size   = cfg_size;
    assign dflt_wdata  = cfg_wdata;

    assign gate_hit = (cfg_off == EE_GATE_OFF) && (cfg_size == CFG_SZ_W'(1)) && !ee_do;

    always_comb begin
        cfg_rdata = dflt_rdata;
        if (gate_hit) cfg_rdata[7:0] = 8'h00;
    end
endmodule

// File: rtl/cfg_eeprom_bridge.sv
module cfg_eeprom_bridge
    import eebr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic [CFG_SZ_W-1:0]  cfg_size,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    output logic                 dflt_wr,
    output logic                 dflt_rd,
    output logic [CFG_OFF_W-1:0] dflt_off,
    output logic [CFG_SZ_W-1:0]  dflt_size,
    output logic [CFG_DW-1:0]    dflt_wdata,
    input  logic [CFG_DW-1:0]    dflt_rdata
);
    ee_pins_t pins;
    logic     ee_do;
    logic     pin_drive;
    logic     pin_release;

    eebr_cfg_route u_route (
        .cfg_wr      (cfg_wr),
        .cfg_rd      (cfg_rd),
        .cfg_off     (cfg_off),
        .cfg_size    (cfg_size),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .ee_do       (ee_do),
        .pin_drive   (pin_drive),
        .pin_release (pin_release),
        .dflt_wr     (dflt_wr),
        .dflt_rd     (dflt_rd),
        .dflt_off    (dflt_off),
        .dflt_size   (dflt_size),
        .dflt_wdata  (dflt_wdata),
        .dflt_rdata  (dflt_rdata)
    );

    eebr_pins u_pins (
        .clk         (clk),
        .rst         (rst),
        .drive       (pin_drive),
        .release_all (pin_release),
        .sk_in       (cfg_wdata[SK_BIT]),
        .di_in       (cfg_wdata[DI_BIT]),
        .pins        (pins)
    );

    eebr_eeprom u_ee (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .dout (ee_do)
    );
endmodule

// File: rtl/eebr_chk.sv
module eebr_chk
    import eebr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_wr,
    input logic                 cfg_rd,
    input logic [CFG_OFF_W-1:0] cfg_off,
    input logic [CFG_SZ_W-1:0]  cfg_size,
    input logic [CFG_DW-1:0]    cfg_wdata,
    input logic [CFG_DW-1:0]    cfg_rdata,
    input logic                 dflt_wr,
    input logic [CFG_DW-1:0]    dflt_wdata,
    input logic [CFG_DW-1:0]    dflt_rdata,
    input ee_pins_t             pins,
    input logic                 ee_do
);
    logic ctrl_wr;
    assign ctrl_wr = cfg_wr && (cfg_off == EE_CLK_OFF || cfg_off == EE_SEL_OFF);

    p_clk_write_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_off == EE_CLK_OFF) |=>
            (pins.cs && pins.sk == $past(cfg_wdata[SK_BIT]) && pins.di == $past(cfg_wdata[DI_BIT])));

    p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_off == EE_SEL_OFF) |=> (!pins.cs && !pins.sk && !pins.di));

    p_pins_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(pins));

    p_gate_low_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_off == EE_GATE_OFF && cfg_size == 3'd1 && !ee_do) |-> (cfg_rdata[7:0] == 8'h00));

    p_read_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && !(cfg_off == EE_GATE_OFF && cfg_size == 3'd1)) |-> (cfg_rdata == dflt_rdata));

    p_write_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !ctrl_wr) |-> (dflt_wr && dflt_wdata == cfg_wdata));

    p_deselect_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !pins.cs |=> ee_do);
endmodule

bind cfg_eeprom_bridge eebr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_off    (cfg_off),
    .cfg_size   (cfg_size),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .dflt_wr    (dflt_wr),
    .dflt_wdata (dflt_wdata),
    .dflt_rdata (dflt_rdata),
    .pins       (pins),
    .ee_do      (ee_do)
);

// File: tb/sim_cfg_eeprom_bridge.sv
module sim_cfg_eeprom_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_off = 8'h00;
    logic [2:0]  cfg_size = 3'd4;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        dflt_wr;
    logic        dflt_rd;
    logic [7:0]  dflt_off;
    logic [2:0]  dflt_size;
    logic [31:0] dflt_wdata;
    logic [31:0] dflt_rdata;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] BASE = 32'hDC39_0055;
    assign dflt_rdata = BASE + {24'h0, dflt_off};

    always #10 clk = ~clk;

    cfg_eeprom_bridge u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_off(cfg_off),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dflt_wr(dflt_wr), .dflt_rd(dflt_rd), .dflt_off(dflt_off), .dflt_size(dflt_size),
        .dflt_wdata(dflt_wdata), .dflt_rdata(dflt_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] off, logic [31:0] data, output logic fwd);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = off; cfg_wdata = data; cfg_size = 3'd1;
        #1 fwd = dflt_wr;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_read(logic [7:0] off, logic [2:0] sz, output logic [31:0] val);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_off = off; cfg_size = sz;
        #1 val = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    // data-out seen through the gated byte: 0x00 means low, 0x55 means high
    task automatic sample_do(output logic b);
        logic [31:0] v;
        cfg_read(8'h00, 3'd1, v);
        b = (v[7:0] != 8'h00);
    endtask

    task automatic pin(logic sk, logic di);
        logic f;
        cfg_write(8'h80, {24'h0, sk, di, 6'h0}, f);
    endtask

    task automatic clk_bit(logic di);
        pin(1'b0, di);
        pin(1'b1, di);
    endtask

    task automatic deselect();
        logic f;
        cfg_write(8'hC0, 32'h0, f);
    endtask

    task automatic send_cmd(logic [1:0] op, logic [5:0] a);
        clk_bit(1'b1);
        for (int i = 1; i >= 0; i--) clk_bit(op[i]);
        for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic t_read_word(logic [5:0] a, logic [15:0] exp, string req, output logic [15:0] got);
        logic b;
        pin(1'b0, 1'b0);
        send_cmd(2'b10, a);
        sample_do(b);
        check("R6 dummy bit", {31'h0, b}, 32'h0);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(1'b0);
            sample_do(b);
            got[i] = b;
        end
        check(req, {16'h0, got}, {16'h0, exp});
        clk_bit(1'b0);
        sample_do(b);
        check("R6 zero after last bit", {31'h0, b}, 32'h0);
        deselect();
    endtask

    task automatic t_reset();
        logic b;
        sample_do(b);
        check("R11 data-out high after reset", {31'h0, b}, 32'h1);
    endtask

    task automatic t_ctrl_writes();
        logic f;
        cfg_write(8'h80, 32'h0000_00C0, f);
        check("R1 0x80 write not forwarded", {31'h0, f}, 32'h0);
        cfg_write(8'hC0, 32'hFFFF_FFFF, f);
        check("R2 0xC0 write not forwarded", {31'h0, f}, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = 8'h44; cfg_wdata = 32'hCAFE_F00D; cfg_size = 3'd4;
        #1;
        check("R4 write forwarded strobe", {31'h0, dflt_wr}, 32'h1);
        check("R4 write forwarded data", dflt_wdata, 32'hCAFE_F00D);
        check("R4 write forwarded offset/size", {21'h0, dflt_size, dflt_off}, {21'h0, 3'd4, 8'h44});
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_gate_sizes();
        logic [31:0] v;
        logic b;
        // put data-out low: read of word 20 parks on a dummy zero
        pin(1'b0, 1'b0);
        send_cmd(2'b10, 6'd20);
        sample_do(b);
        check("R3 data-out low for gating test", {31'h0, b}, 32'h0);
        cfg_read(8'h00, 3'd1, v);
        check("R3 byte read gated", v, BASE & 32'hFFFF_FF00);
        cfg_read(8'h00, 3'd2, v);
        check("R3 2-byte read not gated", v, BASE);
        cfg_read(8'h00, 3'd4, v);
        check("R3 4-byte read not gated", v, BASE);
        cfg_read(8'h10, 3'd1, v);
        check("R4 other offset read", v, BASE + 32'h10);
        deselect();
        cfg_read(8'h00, 3'd1, v);
        check("R3 byte read with data-out high", v, BASE);
    endtask

    task automatic t_leading_zeros();
        logic [15:0] g;
        logic b;
        pin(1'b0, 1'b0);
        clk_bit(1'b0);
        clk_bit(1'b0);
        send_cmd(2'b10, 6'd33);
        sample_do(b);
        check("R5 leading zeros ignored (dummy)", {31'h0, b}, 32'h0);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(1'b0);
            sample_do(b);
            g[i] = b;
        end
        check("R5 word 33 after leading zeros", {16'h0, g}, 32'h0400);
        deselect();
    endtask

    task automatic t_abort();
        logic [15:0] g;
        pin(1'b0, 1'b0);
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b0);
        clk_bit(1'b1);
        deselect();
        t_read_word(6'd32, 16'h0F07, "R8 read after aborted command", g);
    endtask

    task automatic t_nonread();
        logic b;
        logic all_hi;
        all_hi = 1'b1;
        pin(1'b0, 1'b0);
        send_cmd(2'b11, 6'd0);
        for (int i = 0; i < 4; i++) begin
            sample_do(b);
            all_hi &= b;
            clk_bit(1'b0);
        end
        check("R7 data-out high after non-read opcode", {31'h0, all_hi}, 32'h1);
        deselect();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] g;
        logic [15:0] sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_writes();
        t_read_word(6'd0,  16'h0057, "R9 word 0", g);
        t_read_word(6'd15, 16'h0057, "R9 word 15", g);
        t_read_word(6'd34, 16'h0007, "R9 word 34", g);
        t_read_word(6'd20, 16'h0000, "R9 word 20 zero", g);
        sum = 16'(16 * 16'h0057) + 16'h0F07 + 16'h0400 + 16'h0007;
        t_read_word(6'd63, 16'h1234 - sum, "R10 checksum word", g);
        check("R10 image sum equals 0x1234", {16'h0, 16'(sum + g)}, 32'h1234);
        t_gate_sizes();
        t_leading_zeros();
        t_abort();
        t_nonread();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule